// File: doc/BRIEF.md
# Bidirectional Row Scan Register

This block is the row-select shift register of a 240-row passive-matrix display common driver. A single first-line marker bit enters the chain at one end and advances one row for each line clock. The row that holds the marker is the selected row for that line period. Each row output is a 2-bit drive-level code that the analog output switches, which lie outside this block, turn into a voltage.

The two cascade pins swap roles with the direction select. One pin feeds the marker in, and the other presents the last active stage so that a further driver can be chained on. A 2-bit output-count mode shortens the chain to a centred sub-range for panels with 200 or 160 rows. Rows outside that range are held at the non-select level. The inversion signal picks high or low select for the marked row, and a display-off qualifier forces every row to non-select without stopping the scan.

The line clock is sampled by the core clock. A shift takes place on the core clock edge that first sees the line clock low after it was high.

Top module: `row_scan_reg`

## Requirements
- R1: After a synchronous active-low reset every stage is empty. All row codes are 00, and dio1_o and dio2_o are 0.
- R2: The chain moves only on a falling line clock. Holding line_clk high, holding it low, or a rising line_clk leaves every row code and serial output unchanged.
- R3: With dir_up high, dio2_i is the serial input and dio1_i is ignored. The marker enters the lowest active stage and moves one stage toward higher row numbers per shift. dio1_o shows the highest active stage, with dio1_oe=1 and dio2_oe=0.
- R4: With dir_up low, dio1_i is the serial input and dio2_i is ignored. The marker enters the highest active stage and moves toward lower row numbers. dio2_o shows the lowest active stage, with dio2_oe=1 and dio1_oe=0.
- R5: The mode bits are mode[0] and mode[1]. The value {mode[1],mode[0]} = 2'b11 uses rows 1 to 240, 2'b01 uses rows 21 to 220, and 2'b10 uses rows 41 to 200. Row n is bits [2n-1:2n-2] of row_code.
- R6: The prohibited mode 2'b00 behaves exactly like mode 2'b11.
- R7: A row outside the active range always outputs code 00.
- R8: While disp_off_n is low every row outputs code 00. The chain keeps shifting, so the marker position is correct when disp_off_n returns high.
- R9: Row codes: 00 means non-select. 01 means low select and is given for a marked active row with alt_m low. 10 means high select and is given for a marked active row with alt_m high.
- R10: The row codes and serial outputs take their new values on the same core clock edge that detects the falling line clock. No change is visible before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_clk | input | 1 | Line clock; a falling edge advances the chain |
| dir_up | input | 1 | Direction: 1 scans toward higher rows, 0 toward lower rows |
| mode | input | 2 | Output-count mode {mode[1],mode[0]} |
| alt_m | input | 1 | Inversion signal; picks high or low select |
| disp_off_n | input | 1 | Active-low display off; forces all rows to non-select |
| dio1_i | input | 1 | Cascade pin 1 input value |
| dio1_o | output | 1 | Cascade pin 1 output value |
| dio1_oe | output | 1 | Cascade pin 1 output enable |
| dio2_i | input | 1 | Cascade pin 2 input value |
| dio2_o | output | 1 | Cascade pin 2 output value |
| dio2_oe | output | 1 | Cascade pin 2 output enable |
| row_code | output | 480 | Per-row drive code, 2 bits per row, row 1 in bits [1:0] |

## Verification
A stage that holds a wrong bit shows at once on row_code, in the cycle after the shift that put it there. This holds unless the row is out of range or display-off is active. In those cases the fault only surfaces once the marker reaches the far end of the range and appears on the serial output. A wrong range boundary shows as a marker that appears on or skips row 1, 21 or 41, or that leaves on the serial pin one shift early or late. A fault in edge detection shows as a shift on the wrong line clock edge, or two shifts in one edge. The bench therefore compares the full row vector and both serial pins after every single shift.

// File: rtl/row_scan_pkg.sv
`timescale 1ns/1ps
// Shared types for the row scan register.
// Assumes: the mode value is {mode[1], mode[0]} as seen at the block pins.
package row_scan_pkg;

    // Output-count modes of the scan chain.
    typedef enum logic [1:0] {
        SCAN_BANNED = 2'b00,
        SCAN_MID    = 2'b01,
        SCAN_NARROW = 2'b10,
        SCAN_FULL   = 2'b11
    } scan_mode_e;

    // Drive-level code per row.
    typedef enum logic [1:0] {
        DRV_NONSEL = 2'b00,
        DRV_SEL_LO = 2'b01,
        DRV_SEL_HI = 2'b10
    } drv_code_e;

endpackage

// File: rtl/scan_range_dec.sv
`timescale 1ns/1ps
// Decodes the output-count mode into the first and last active stage
// and a per-stage activity mask.
// Assumes: MID_SKIP and NARROW_SKIP are less than half of NUM_ROWS.
module scan_range_dec
    import row_scan_pkg::*;
#(
    parameter int NUM_ROWS    = 240,
    parameter int MID_SKIP    = 20,
    parameter int NARROW_SKIP = 40,
    localparam int IDXW       = $clog2(NUM_ROWS)
) (
    input  logic [1:0]          mode,
    output logic [IDXW-1:0]     lo_idx,
    output logic [IDXW-1:0]     hi_idx,
    output logic [NUM_ROWS-1:0] active
);
    localparam logic [IDXW-1:0] FULL_LO   = '0;
    localparam logic [IDXW-1:0] FULL_HI   = IDXW'(NUM_ROWS - 1);
    localparam logic [IDXW-1:0] MID_LO    = IDXW'(MID_SKIP);
    localparam logic [IDXW-1:0] MID_HI    = IDXW'(NUM_ROWS - 1 - MID_SKIP);
    localparam logic [IDXW-1:0] NARROW_LO = IDXW'(NARROW_SKIP);
    localparam logic [IDXW-1:0] NARROW_HI = IDXW'(NUM_ROWS - 1 - NARROW_SKIP);

    // Pick range ends; the banned code falls back to the full range.
    always_comb begin
        case (scan_mode_e'(mode))
            SCAN_MID:    begin lo_idx = MID_LO;    hi_idx = MID_HI;    end
            SCAN_NARROW: begin lo_idx = NARROW_LO; hi_idx = NARROW_HI; end
            default:     begin lo_idx = FULL_LO;   hi_idx = FULL_HI;   end
        endcase
    end

    // One range compare per stage.
    for (genvar gi = 0; gi < NUM_ROWS; gi++) begin : g_mask
        assign active[gi] = (IDXW'(gi) >= lo_idx) && (IDXW'(gi) <= hi_idx);
    end

endmodule

// File: rtl/scan_chain.sv
`timescale 1ns/1ps
// Bidirectional marker shift register. Stages outside the active range
// load zero on each shift; the entry stage loads the serial input.
// Assumes: shift_en is a single-cycle pulse per line.
module scan_chain #(
    parameter int NUM_ROWS = 240,
    localparam int IDXW    = $clog2(NUM_ROWS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                shift_en,
    input  logic                dir_up,
    input  logic                ser_in,
    input  logic [IDXW-1:0]     lo_idx,
    input  logic [IDXW-1:0]     hi_idx,
    input  logic [NUM_ROWS-1:0] active,
    output logic [NUM_ROWS-1:0] stage_q,
    output logic                ser_out
);
    logic [NUM_ROWS-1:0] stage_d;
    logic [IDXW-1:0]     entry_idx;

    assign entry_idx = dir_up ? lo_idx : hi_idx;

    // Next value per stage from its neighbour or the serial input.
    for (genvar gi = 0; gi < NUM_ROWS; gi++) begin : g_stage
        logic from_below;
        logic from_above;
        if (gi == 0) begin : g_first
            assign from_below = 1'b0;
        end else begin : g_below
            assign from_below = stage_q[gi-1];
        end
        if (gi == NUM_ROWS - 1) begin : g_last
            assign from_above = 1'b0;
        end else begin : g_above
            assign from_above = stage_q[gi+1];
        end
        assign stage_d[gi] = !active[gi]            ? 1'b0   :
                             (IDXW'(gi) == entry_idx) ? ser_in :
                             dir_up                 ? from_below : from_above;
    end

    // Stage register: cleared on reset, loaded on each line shift.
    always_ff @(posedge clk) begin
        if (!rst_n)        stage_q <= '0;
        else if (shift_en) stage_q <= stage_d;
    end

    // Far end of the active range drives the cascade output.
    assign ser_out = dir_up ? stage_q[hi_idx] : stage_q[lo_idx];

    AST_HOLD_WITHOUT_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(stage_q)); // R2

    AST_ENTRY_LOADS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(shift_en) && $stable(entry_idx)) |-> (stage_q[entry_idx] == $past(ser_in))); // R3

endmodule

// File: rtl/row_level_enc.sv
`timescale 1ns/1ps
// Turns each stage bit into a drive-level code, applying the range mask,
// the display-off qualifier and the inversion signal.
// Assumes: blank is active high and already qualified.
module row_level_enc
    import row_scan_pkg::*;
#(
    parameter int NUM_ROWS = 240
) (
    input  logic                  alt_m,
    input  logic                  blank,
    input  logic [NUM_ROWS-1:0]   stage_q,
    input  logic [NUM_ROWS-1:0]   active,
    output logic [2*NUM_ROWS-1:0] row_code
);
    // Per-row level selection.
    for (genvar gi = 0; gi < NUM_ROWS; gi++) begin : g_row
        logic marked;
        assign marked = stage_q[gi] && active[gi] && !blank;
        assign row_code[2*gi +: 2] = !marked ? DRV_NONSEL :
                                     alt_m   ? DRV_SEL_HI : DRV_SEL_LO;
    end

endmodule

// File: rtl/row_scan_reg.sv
`timescale 1ns/1ps
// Row-select scan register of a common driver: detects the falling line
// clock, routes the cascade pins by direction, and drives per-row codes.
// Assumes: line_clk is already synchronous to clk.
module row_scan_reg
    import row_scan_pkg::*;
#(
    parameter int NUM_ROWS    = 240,
    parameter int MID_SKIP    = 20,
    parameter int NARROW_SKIP = 40,
    localparam int IDXW       = $clog2(NUM_ROWS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  line_clk,
    input  logic                  dir_up,
    input  logic [1:0]            mode,
    input  logic                  alt_m,
    input  logic                  disp_off_n,
    input  logic                  dio1_i,
    output logic                  dio1_o,
    output logic                  dio1_oe,
    input  logic                  dio2_i,
    output logic                  dio2_o,
    output logic                  dio2_oe,
    output logic [2*NUM_ROWS-1:0] row_code
);
    logic                line_q;
    logic                shift_en;
    logic                ser_in;
    logic                ser_out;
    logic [IDXW-1:0]     lo_idx;
    logic [IDXW-1:0]     hi_idx;
    logic [NUM_ROWS-1:0] active;
    logic [NUM_ROWS-1:0] stage_q;

    // Previous line clock level for falling-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) line_q <= 1'b0;
        else        line_q <= line_clk;
    end

    assign shift_en = line_q && !line_clk;

    // Cascade pin routing by direction.
    assign ser_in  = dir_up ? dio2_i : dio1_i;
    assign dio1_oe = dir_up;
    assign dio2_oe = !dir_up;
    assign dio1_o  = dir_up ? ser_out : 1'b0;
    assign dio2_o  = dir_up ? 1'b0 : ser_out;

    scan_range_dec #(
        .NUM_ROWS    (NUM_ROWS),
        .MID_SKIP    (MID_SKIP),
        .NARROW_SKIP (NARROW_SKIP)
    ) range_i (
        .mode   (mode),
        .lo_idx (lo_idx),
        .hi_idx (hi_idx),
        .active (active)
    );

    scan_chain #(
        .NUM_ROWS (NUM_ROWS)
    ) chain_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shift_en),
        .dir_up   (dir_up),
        .ser_in   (ser_in),
        .lo_idx   (lo_idx),
        .hi_idx   (hi_idx),
        .active   (active),
        .stage_q  (stage_q),
        .ser_out  (ser_out)
    );

    row_level_enc #(
        .NUM_ROWS (NUM_ROWS)
    ) enc_i (
        .alt_m    (alt_m),
        .blank    (!disp_off_n),
        .stage_q  (stage_q),
        .active   (active),
        .row_code (row_code)
    );

    AST_BLANK_ALL_ROWS: assert property (@(posedge clk) disable iff (!rst_n)
        !disp_off_n |-> (row_code == '0)); // R8

    AST_EDGE_ROWS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == SCAN_MID || mode == SCAN_NARROW) |->
        (row_code[1:0] == DRV_NONSEL && row_code[2*NUM_ROWS-1 -: 2] == DRV_NONSEL)); // R7

    AST_ONE_DRIVER: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({dio1_oe, dio2_oe}) == 1); // R4

    AST_UNSELECTED_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (stage_q == '0) |-> (row_code == '0)); // R9

endmodule

// File: tb/row_scan_reg_tb_top.sv
`timescale 1ns/1ps
module row_scan_reg_tb_top;
    localparam int N = 240;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           line_clk = 1'b0;
    logic           dir_up = 1'b1;
    logic [1:0]     mode = 2'b11;
    logic           alt_m = 1'b1;
    logic           disp_off_n = 1'b1;
    logic           dio1_i = 1'b0;
    logic           dio2_i = 1'b0;
    logic           dio1_o, dio1_oe, dio2_o, dio2_oe;
    logic [2*N-1:0] row_code;

    int n_checks = 0;
    int n_fail   = 0;
    logic [N-1:0] mq = '0;

    always #2.5 clk = ~clk;

    row_scan_reg dut_i (
        .clk(clk), .rst_n(rst_n), .line_clk(line_clk), .dir_up(dir_up),
        .mode(mode), .alt_m(alt_m), .disp_off_n(disp_off_n),
        .dio1_i(dio1_i), .dio1_o(dio1_o), .dio1_oe(dio1_oe),
        .dio2_i(dio2_i), .dio2_o(dio2_o), .dio2_oe(dio2_oe),
        .row_code(row_code)
    );

    function automatic int range_lo(input logic [1:0] md);
        return (md == 2'b01) ? 20 : (md == 2'b10) ? 40 : 0;
    endfunction
    function automatic int range_hi(input logic [1:0] md);
        return (md == 2'b01) ? 219 : (md == 2'b10) ? 199 : 239;
    endfunction

    // Compare all outputs against the bench model.
    task automatic check_all(input string req);
        int lo = range_lo(mode);
        int hi = range_hi(mode);
        logic [2*N-1:0] exp_code = '0;
        logic e1, e2;
        for (int i = lo; i <= hi; i++)
            if (mq[i] && disp_off_n) exp_code[2*i +: 2] = alt_m ? 2'b10 : 2'b01;
        n_checks++;
        if (row_code !== exp_code) begin
            n_fail++;
            for (int i = 0; i < N; i++)
                if (row_code[2*i +: 2] !== exp_code[2*i +: 2]) begin
                    $display("FAIL %s row %0d code actual %b expected %b", req, i+1,
                             row_code[2*i +: 2], exp_code[2*i +: 2]);
                    break;
                end
        end
        e1 = dir_up ? mq[hi] : 1'b0;
        e2 = dir_up ? 1'b0 : mq[lo];
        n_checks++;
        if ({dio1_o, dio1_oe, dio2_o, dio2_oe} !== {e1, dir_up, e2, !dir_up}) begin
            n_fail++;
            $display("FAIL %s pins {o1,oe1,o2,oe2} actual %b expected %b", req,
                     {dio1_o, dio1_oe, dio2_o, dio2_oe}, {e1, dir_up, e2, !dir_up});
        end
    endtask

    // Bench model of one shift.
    task automatic model_shift(input logic din);
        int lo = range_lo(mode);
        int hi = range_hi(mode);
        logic [N-1:0] nq = '0;
        for (int i = lo; i <= hi; i++) begin
            if (dir_up) nq[i] = (i == lo) ? din : mq[i-1];
            else        nq[i] = (i == hi) ? din : mq[i+1];
        end
        mq = nq;
    endtask

    // One line period; the unused pin carries a 1 to show it is ignored.
    task automatic step(input logic din);
        @(negedge clk);
        line_clk = 1'b1;
        dio1_i = dir_up ? 1'b1 : din;
        dio2_i = dir_up ? din : 1'b1;
        @(negedge clk);
        line_clk = 1'b0;
        @(negedge clk);
        model_shift(din);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        line_clk = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        mq = '0;
    endtask

    task automatic t_reset();
        do_reset();
        check_all("R1");
    endtask

    task automatic t_right_full();
        dir_up = 1'b1; mode = 2'b11; alt_m = 1'b1;
        do_reset();
        step(1'b1);
        check_all("R3 R5 R9");
        for (int k = 0; k < 238; k++) step(1'b0);
        check_all("R3");
        step(1'b0);
        check_all("R3 last row");
        step(1'b0);
        check_all("R3 exit");
    endtask

    task automatic t_left_mid();
        dir_up = 1'b0; mode = 2'b01; alt_m = 1'b0;
        do_reset();
        step(1'b1);
        check_all("R4 R5 R9");
        for (int k = 0; k < 199; k++) begin
            step(1'b0);
            check_all("R4 R7");
        end
        step(1'b0);
        check_all("R4 exit");
    endtask

    task automatic t_narrow();
        dir_up = 1'b1; mode = 2'b10; alt_m = 1'b1;
        do_reset();
        step(1'b1); step(1'b1); step(1'b0);
        check_all("R5 R7 narrow");
        for (int k = 0; k < 160; k++) begin
            step(1'b0);
            check_all("R5 R7 narrow scan");
        end
    endtask

    task automatic t_banned();
        dir_up = 1'b0; mode = 2'b00; alt_m = 1'b1;
        do_reset();
        step(1'b1);
        check_all("R6 entry at row 240");
        for (int k = 0; k < 239; k++) step(1'b0);
        check_all("R6 row 1");
    endtask

    task automatic t_edges();
        dir_up = 1'b1; mode = 2'b11; alt_m = 1'b1;
        do_reset();
        step(1'b1);
        @(negedge clk);
        dio2_i = 1'b1;
        line_clk = 1'b1;
        repeat (4) @(negedge clk);
        check_all("R2 rise and high");
        line_clk = 1'b0;
        check_all("R10 before edge");
        @(negedge clk);
        model_shift(1'b1);
        check_all("R10 after edge");
        repeat (4) @(negedge clk);
        check_all("R2 held low");
    endtask

    task automatic t_dispoff();
        dir_up = 1'b1; mode = 2'b11; alt_m = 1'b0;
        do_reset();
        step(1'b1);
        disp_off_n = 1'b0;
        @(negedge clk);
        check_all("R8 blank");
        for (int k = 0; k < 5; k++) step(1'b0);
        check_all("R8 blank while shifting");
        disp_off_n = 1'b1;
        @(negedge clk);
        check_all("R8 resume at row 6");
    endtask

    initial begin
        t_reset();
        t_right_full();
        t_left_mid();
        t_narrow();
        t_banned();
        t_edges();
        t_dispoff();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule